// File: doc/BRIEF.md
# Four-Channel Prioritized Transfer Engine

This block moves data between memory locations without processor involvement. Four channels each hold a programmed source address, destination address, unit count and control word. When a channel is armed it becomes active, either at once or when a matching external start pulse arrives. The engine then serves active channels one unit at a time: it issues a memory read, captures the returned data, and issues a memory write with that data.

Each step is granted to the lowest-numbered active channel. Per channel, the addresses step up, step down or stay put. The destination has an extra mode that steps up and then reloads its start address when the block completes. Each channel masks its addresses to its own width, and a count of zero means a channel-specific maximum.

Channels 1 and 2 can serve an audio FIFO. In that mode they move 32-bit units to a fixed destination, four units per start pulse. When a block completes, the channel can raise an interrupt pulse and can stay enabled for the next start pulse.

Top module: `dma_ctrl`

## Requirements
- R1: Configuration writes use `cfg_ch_i` to pick the channel and `cfg_sel_i` to pick the register: 0 source low half, 1 source high half, 2 destination low half, 3 destination high half, 4 count, 5 control. The control word has these fields: [1:0] destination mode, [3:2] source mode, [4] repeat, [5] wide, [7:6] start timing, [8] interrupt enable, [9] enable. A control write with enable set copies source, destination and count into the working registers. If the timing is 0, the channel becomes active on the next cycle. After reset, no channel is enabled or active, no memory request is raised and no interrupt is asserted.
- R2: A control write with enable clear drops the channel's `active_o` and `enable_o` bits on the next cycle. A transfer already in flight then finishes, but no further transfer is started for that channel.
- R3: When several channels are active, the next read is issued for the lowest-numbered one.
- R4: A unit is 4 bytes when wide is set and 2 bytes otherwise, and `mem_wide_o` shows which. Issued addresses are aligned down to the unit: bits [1:0] are cleared for 4-byte units and bit [0] for 2-byte units.
- R5: Channel 0's source is masked to 27 bits and the other sources to 28 bits. Channel 3's destination is masked to 28 bits and the other destinations to 31 bits. The mask is applied before every transfer, so a stepped address wraps inside its mask.
- R6: Mode codes: 0 steps up by the unit size, 1 steps down, 2 stays fixed. Code 3 steps up on the destination and acts as fixed on the source.
- R7: A count of zero means 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3.
- R8: When the last unit of a block is written, the channel becomes inactive. If repeat is set, the count is reloaded from the count register, the destination is reloaded when its mode is 3, and the channel stays enabled. Otherwise the enable bit is cleared.
- R9: If interrupt enable is set, block completion gives a one-cycle pulse on that channel's `irq_o` bit in the cycle after the final write acknowledge.
- R10: Channel 1 or 2 with timing 3 uses 4-byte units and a fixed destination whatever its control bits say. Each audio start pulse loads a count of exactly 4.
- R11: `trig_i` bit 0 (vertical blank) starts enabled channels with timing 1, and bit 1 (horizontal blank) starts those with timing 2. Bit 2 (audio FIFO) starts only channels 1 and 2 with timing 3. Channels 0 and 3 with timing 3 are never started by these pulses.
- R12: A read request and its address are held until `mem_rd_valid_i`. Data read on that cycle is presented with a write request on the next cycle, and the write is held until `mem_wr_valid_i`. Read and write requests are never raised together.
- R13: A start pulse that arrives in the same cycle as a repeating channel's final write acknowledge leaves the channel active. The channel then runs another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel to write |
| cfg_sel_i | input | 3 | Register to write |
| cfg_wdata_i | input | 16 | Write data |
| trig_i | input | 3 | Start pulses: vertical blank, horizontal blank, audio FIFO |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_wr_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Address of the current request |
| mem_wide_o | output | 1 | 1 for a 4-byte unit, 0 for a 2-byte unit |
| mem_wdata_o | output | 32 | Write data |
| mem_rd_valid_i | input | 1 | Read data valid, ends the read request |
| mem_rd_data_i | input | 32 | Read data |
| mem_wr_valid_i | input | 1 | Write acknowledge |
| active_o | output | 4 | Channels waiting for service |
| enable_o | output | 4 | Channel enable bits |
| irq_o | output | 4 | Block-completion interrupt pulses |

## Verification
The case that needs care is a start pulse landing in the same cycle as the final write acknowledge of a repeating channel. In that cycle, completion clears the active bit and the start pulse sets it. The bench makes the memory model acknowledge reads at once but hold off the write. It then raises the write acknowledge and a vertical-blank pulse on the same clock edge. The bench checks that the channel is still active after that edge and that exactly one more block follows.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH   = 4;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int CW    = 16;
  localparam int CTL_W = 10;

  localparam logic [2:0] SEL_SRC_LO = 3'd0;
  localparam logic [2:0] SEL_SRC_HI = 3'd1;
  localparam logic [2:0] SEL_DST_LO = 3'd2;
  localparam logic [2:0] SEL_DST_HI = 3'd3;
  localparam logic [2:0] SEL_CNT    = 3'd4;
  localparam logic [2:0] SEL_CTL    = 3'd5;

  localparam int B_DADJ = 0;
  localparam int B_SADJ = 2;
  localparam int B_RPT  = 4;
  localparam int B_WIDE = 5;
  localparam int B_TIME = 6;
  localparam int B_IRQ  = 8;
  localparam int B_EN   = 9;

  typedef enum logic [1:0] {
    ADJ_INC = 2'd0,
    ADJ_DEC = 2'd1,
    ADJ_FIX = 2'd2,
    ADJ_RLD = 2'd3
  } adj_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;

  function automatic logic [AW-1:0] src_mask(input int ch);
    return (ch == 0) ? 32'h07FF_FFFF : 32'h0FFF_FFFF;
  endfunction

  function automatic logic [AW-1:0] dst_mask(input int ch);
    return (ch == NCH-1) ? 32'h0FFF_FFFF : 32'h7FFF_FFFF;
  endfunction

  function automatic logic [CW:0] cnt_full(input int ch);
    return (ch == NCH-1) ? 17'h1_0000 : 17'h0_4000;
  endfunction
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [2:0]    trig_i,
  input  logic          done_i,
  output logic          active_o,
  output logic          enable_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wide_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] SMASK  = src_mask(CH);
  localparam logic [AW-1:0] DMASK  = dst_mask(CH);
  localparam logic [CW:0]   CFULL  = cnt_full(CH);
  localparam int            PAIR   = (CH + 1) / 2;
  localparam bit            IS_SND = (CH == 1) || (CH == 2);

  logic [AW-1:0]    src_r, dst_r, src_q, dst_q;
  logic [CW-1:0]    cnt_r;
  logic [CTL_W-1:0] ctl_r;
  logic [CW:0]      cnt_q;
  logic             act_q, irq_q;

  logic [AW-1:0]    n_src_r, n_dst_r, n_src_q, n_dst_q;
  logic [CW-1:0]    n_cnt_r;
  logic [CTL_W-1:0] n_ctl_r;
  logic [CW:0]      n_cnt_q;
  logic             n_act, n_irq;

  logic          snd, wide;
  adj_e          sadj, dadj;
  logic [AW-1:0] unit, amask, src_m, dst_m, src_step, dst_step;
  logic [CW:0]   cnt_left;

  assign snd   = IS_SND && (ctl_r[B_TIME +: 2] == 2'd3);
  assign wide  = ctl_r[B_WIDE] | snd;
  assign unit  = wide ? 32'd4 : 32'd2;
  assign amask = wide ? ~32'h3 : ~32'h1;
  assign sadj  = adj_e'(ctl_r[B_SADJ +: 2]);
  assign dadj  = snd ? ADJ_FIX : adj_e'(ctl_r[B_DADJ +: 2]);
  assign src_m = src_q & SMASK;
  assign dst_m = dst_q & DMASK;

  always_comb begin
    unique case (sadj)
      ADJ_INC: src_step = src_m + unit;
      ADJ_DEC: src_step = src_m - unit;
      default: src_step = src_m;
    endcase
    unique case (dadj)
      ADJ_INC, ADJ_RLD: dst_step = dst_m + unit;
      ADJ_DEC:          dst_step = dst_m - unit;
      default:          dst_step = dst_m;
    endcase
  end

  assign cnt_left = ((cnt_q == '0) ? CFULL : cnt_q) - 1'b1;

  always_comb begin
    logic [1:0] t;
    logic [2:0] code;
    logic       fire;
    n_src_r = src_r;
    n_dst_r = dst_r;
    n_cnt_r = cnt_r;
    n_ctl_r = ctl_r;
    n_src_q = src_q;
    n_dst_q = dst_q;
    n_cnt_q = cnt_q;
    n_act   = act_q;
    n_irq   = 1'b0;
    if (we_i) begin
      unique case (sel_i)
        SEL_SRC_LO: n_src_r[15:0]  = wdata_i;
        SEL_SRC_HI: n_src_r[31:16] = wdata_i;
        SEL_DST_LO: n_dst_r[15:0]  = wdata_i;
        SEL_DST_HI: n_dst_r[31:16] = wdata_i;
        SEL_CNT:    n_cnt_r        = wdata_i;
        SEL_CTL: begin
          n_ctl_r = wdata_i[CTL_W-1:0];
          if (wdata_i[B_EN]) begin
            n_src_q = src_r;
            n_dst_q = dst_r;
            n_cnt_q = {1'b0, cnt_r};
            n_act   = (wdata_i[B_TIME +: 2] == 2'd0);
          end else begin
            n_act = 1'b0;
          end
        end
        default: ;
      endcase
    end else if (done_i && ctl_r[B_EN]) begin
      // register write above takes precedence over the step update
      n_src_q = src_step;
      n_dst_q = dst_step;
      if (cnt_left == '0) begin
        n_act = 1'b0;
        n_irq = ctl_r[B_IRQ];
        if (ctl_r[B_RPT]) begin
          n_cnt_q = {1'b0, cnt_r};
          if (dadj == ADJ_RLD) n_dst_q = dst_r;
        end else begin
          n_cnt_q = cnt_left;
          n_ctl_r[B_EN] = 1'b0;
        end
      end else begin
        n_cnt_q = cnt_left;
      end
    end
    // start pulses see the post-update control word
    t    = n_ctl_r[B_TIME +: 2];
    code = (t == 2'd3) ? 3'(3 + PAIR) : {1'b0, t};
    fire = n_ctl_r[B_EN] && (((code == 3'd1) && trig_i[0]) ||
                             ((code == 3'd2) && trig_i[1]) ||
                             ((code == 3'd4) && trig_i[2]));
    if (fire) begin
      n_act = 1'b1;
      if (code == 3'd4) n_cnt_q = 17'd4;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_r <= '0;
      dst_r <= '0;
      cnt_r <= '0;
      ctl_r <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      src_r <= n_src_r;
      dst_r <= n_dst_r;
      cnt_r <= n_cnt_r;
      ctl_r <= n_ctl_r;
      src_q <= n_src_q;
      dst_q <= n_dst_q;
      cnt_q <= n_cnt_q;
      act_q <= n_act;
      irq_q <= n_irq;
    end
  end

  assign active_o  = act_q;
  assign enable_o  = ctl_r[B_EN];
  assign rd_addr_o = src_m & amask;
  assign wr_addr_o = dst_m & amask;
  assign wide_o    = wide;
  assign irq_o     = irq_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_ch_i,
  input  logic [2:0]  cfg_sel_i,
  input  logic [15:0] cfg_wdata_i,
  input  logic [2:0]  trig_i,
  output logic        mem_rd_req_o,
  output logic        mem_wr_req_o,
  output logic [31:0] mem_addr_o,
  output logic        mem_wide_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_rd_valid_i,
  input  logic [31:0] mem_rd_data_i,
  input  logic        mem_wr_valid_i,
  output logic [3:0]  active_o,
  output logic [3:0]  enable_o,
  output logic [3:0]  irq_o
);
  localparam int IW = $clog2(NCH);

  logic [AW-1:0] ch_rd_a [NCH];
  logic [AW-1:0] ch_wr_a [NCH];
  logic [NCH-1:0] ch_wide, ch_act, ch_en, ch_irq, ch_done;

  st_e           st_q;
  logic [IW-1:0] sel_q, pick;
  logic          any;
  logic [AW-1:0] rd_a_q, wr_a_q;
  logic [DW-1:0] data_q;
  logic          wide_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_done[g] = (st_q == ST_WR) && mem_wr_valid_i && (sel_q == IW'(g));
    dma_chan #(.CH(g)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cfg_we_i && (cfg_ch_i == IW'(g))),
      .sel_i     (cfg_sel_i),
      .wdata_i   (cfg_wdata_i),
      .trig_i    (trig_i),
      .done_i    (ch_done[g]),
      .active_o  (ch_act[g]),
      .enable_o  (ch_en[g]),
      .rd_addr_o (ch_rd_a[g]),
      .wr_addr_o (ch_wr_a[g]),
      .wide_o    (ch_wide[g]),
      .irq_o     (ch_irq[g])
    );
  end

  dma_arb #(.N(NCH)) u_arb (
    .req_i (ch_act),
    .idx_o (pick),
    .any_o (any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      rd_a_q <= '0;
      wr_a_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any) begin
          sel_q  <= pick;
          rd_a_q <= ch_rd_a[pick];
          wr_a_q <= ch_wr_a[pick];
          wide_q <= ch_wide[pick];
          st_q   <= ST_RD;
        end
        ST_RD: if (mem_rd_valid_i) begin
          data_q <= mem_rd_data_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_wr_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_req_o = (st_q == ST_RD);
  assign mem_wr_req_o = (st_q == ST_WR);
  assign mem_addr_o   = (st_q == ST_WR) ? wr_a_q : rd_a_q;
  assign mem_wide_o   = wide_q;
  assign mem_wdata_o  = data_q;
  assign active_o     = ch_act;
  assign enable_o     = ch_en;
  assign irq_o        = ch_irq;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_rd_req_o,
  input logic        mem_wr_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_wide_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_rd_valid_i,
  input logic [31:0] mem_rd_data_i,
  input logic        mem_wr_valid_i,
  input logic [3:0]  active_o,
  input logic [3:0]  enable_o,
  input logic [3:0]  irq_o
);
  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && !mem_rd_valid_i |=> mem_rd_req_o && $stable(mem_addr_o));

  assert_wr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o && !mem_wr_valid_i |=>
      mem_wr_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_rd_to_wr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o && mem_rd_valid_i |=>
      mem_wr_req_o && (mem_wdata_o == $past(mem_rd_data_i)));

  assert_req_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_req_o && mem_wr_req_o));

  assert_addr_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o || mem_wr_req_o) |->
      (mem_wide_o ? (mem_addr_o[1:0] == 2'b00) : !mem_addr_o[0]));

  assert_irq_after_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(mem_wr_req_o && mem_wr_valid_i));

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  assert_active_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o & ~enable_o) == 4'b0000);
endmodule

bind dma_ctrl dma_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mem_rd_req_o   (mem_rd_req_o),
  .mem_wr_req_o   (mem_wr_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_wide_o     (mem_wide_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_rd_valid_i (mem_rd_valid_i),
  .mem_rd_data_i  (mem_rd_data_i),
  .mem_wr_valid_i (mem_wr_valid_i),
  .active_o       (active_o),
  .enable_o       (enable_o),
  .irq_o          (irq_o)
);

// File: tb/sim_dma_ctrl.sv
module sim_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  trig = '0;
  logic        rd_req, wr_req, wide, rd_valid, wr_valid;
  logic [31:0] addr, wdata, rd_data;
  logic [3:0]  active, enable, irq;
  logic        auto_rd = 1'b1, auto_wr = 1'b1, man_wr = 1'b0;

  int checks = 0, fails = 0;
  int rd_n = 0, wr_n = 0;
  int irq_cnt [4] = '{0, 0, 0, 0};
  logic [31:0] rd_log [64];
  logic [31:0] wr_log [64];
  logic [31:0] wd_log [64];
  logic        wide_log [64];

  always #2 clk = ~clk;

  assign rd_valid = rd_req & auto_rd;
  assign wr_valid = wr_req & (auto_wr | man_wr);
  assign rd_data  = ~addr ^ 32'hA5C3_0000;

  dma_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .trig_i(trig),
    .mem_rd_req_o(rd_req), .mem_wr_req_o(wr_req), .mem_addr_o(addr),
    .mem_wide_o(wide), .mem_wdata_o(wdata), .mem_rd_valid_i(rd_valid),
    .mem_rd_data_i(rd_data), .mem_wr_valid_i(wr_valid),
    .active_o(active), .enable_o(enable), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (rd_req && rd_valid) begin
      rd_log[rd_n % 64]   <= addr;
      wide_log[rd_n % 64] <= wide;
      rd_n <= rd_n + 1;
    end
    if (wr_req && wr_valid) begin
      wr_log[wr_n % 64] <= addr;
      wd_log[wr_n % 64] <= wdata;
      wr_n <= wr_n + 1;
    end
    for (int k = 0; k < 4; k++) if (irq[k]) irq_cnt[k] <= irq_cnt[k] + 1;
  end

  typedef struct packed {
    logic [1:0]  ch;
    logic [15:0] ctl;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic [7:0]  n;
    logic [31:0] rd0;
    logic [31:0] wr0;
    logic [31:0] rd1;
    logic [31:0] wr1;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0200, 32'h0000_1001, 32'h0200_0003, 16'd2, 8'd2, 32'h0000_1000, 32'h0200_0002, 32'h0000_1002, 32'h0200_0004},
    '{2'd1, 16'h0225, 32'h0300_0010, 32'h0600_0020, 16'd2, 8'd2, 32'h0300_0010, 32'h0600_0020, 32'h0300_000C, 32'h0600_001C},
    '{2'd2, 16'h020A, 32'h0800_0100, 32'h0700_0200, 16'd3, 8'd3, 32'h0800_0100, 32'h0700_0200, 32'h0800_0100, 32'h0700_0200},
    '{2'd0, 16'h0200, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'd2, 8'd2, 32'h07FF_FFF0, 32'h7FFF_FFF0, 32'h07FF_FFF2, 32'h7FFF_FFF2},
    '{2'd3, 16'h0220, 32'hF000_0004, 32'hFFFF_FFFC, 16'd2, 8'd2, 32'h0000_0004, 32'h0FFF_FFFC, 32'h0000_0008, 32'h0000_0000},
    '{2'd1, 16'h020F, 32'h0200_0040, 32'h0200_0080, 16'd2, 8'd2, 32'h0200_0040, 32'h0200_0080, 32'h0200_0040, 32'h0200_0082},
    '{2'd2, 16'h0200, 32'h1FFF_FFFE, 32'h8000_0010, 16'd2, 8'd2, 32'h0FFF_FFFE, 32'h0000_0010, 32'h0000_0000, 32'h0000_0012}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] n, input logic [15:0] ctl);
    cfg(ch, 3'd0, s[15:0]);
    cfg(ch, 3'd1, s[31:16]);
    cfg(ch, 3'd2, d[15:0]);
    cfg(ch, 3'd3, d[31:16]);
    cfg(ch, 3'd4, n);
    cfg(ch, 3'd5, ctl);
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk);
    trig = v;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle(input int limit);
    int c = 0;
    while ((active != 4'b0 || rd_req || wr_req) && c < limit) begin
      @(negedge clk);
      c++;
    end
    if (c >= limit) begin
      checks++; fails++;
      $display("FAIL wait_idle actual=%h expected=%h", active, 4'b0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    summary();
  end

  initial begin
    int b, rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset req", {30'b0, rd_req, wr_req}, 32'h0);
    chk("R1 reset act/en/irq", {20'b0, active, enable, irq}, 32'h0);

    // table walk: R4 R5 R6 R8 R12
    for (int i = 0; i < NV; i++) begin
      b = wr_n; rb = rd_n;
      prog(VECS[i].ch, VECS[i].src, VECS[i].dst, VECS[i].cnt, VECS[i].ctl);
      chk("R1 armed active", {31'b0, active[VECS[i].ch]}, 32'h1);
      wait_idle(200);
      chk("R7 count", wr_n - b, {24'b0, VECS[i].n});
      chk("R5 rd0", rd_log[rb % 64], VECS[i].rd0);
      chk("R5 wr0", wr_log[b % 64], VECS[i].wr0);
      chk("R6 rd1", rd_log[(rb + 1) % 64], VECS[i].rd1);
      chk("R6 wr1", wr_log[(b + 1) % 64], VECS[i].wr1);
      chk("R4 wide", {31'b0, wide_log[rb % 64]}, {31'b0, VECS[i].ctl[5]});
      chk("R12 wdata", wd_log[b % 64], ~VECS[i].rd0 ^ 32'hA5C3_0000);
      chk("R8 en cleared", {31'b0, enable[VECS[i].ch]}, 32'h0);
    end

    // R3 R11: priority and trigger matching
    prog(2'd3, 32'h0000_3000, 32'h0200_0000, 16'd1, 16'h024A);
    prog(2'd2, 32'h0000_2000, 32'h0200_0000, 16'd1, 16'h024A);
    prog(2'd1, 32'h0000_1000, 32'h0200_0000, 16'd1, 16'h024A);
    prog(2'd0, 32'h0000_0F00, 32'h0200_0000, 16'd1, 16'h028A);
    chk("R11 armed idle", {28'b0, active}, 32'h0);
    rb = rd_n;
    pulse(3'b001);
    chk("R11 vblank set", {28'b0, active}, 32'he);
    wait_idle(200);
    chk("R3 first", rd_log[rb % 64], 32'h0000_1000);
    chk("R3 second", rd_log[(rb + 1) % 64], 32'h0000_2000);
    chk("R3 third", rd_log[(rb + 2) % 64], 32'h0000_3000);
    cfg(2'd0, 3'd5, 16'h0000);

    // R2: disable while a read is stalled
    auto_rd = 1'b0;
    rb = rd_n;
    prog(2'd0, 32'h0000_4000, 32'h0200_1000, 16'd5, 16'h0200);
    repeat (3) @(negedge clk);
    chk("R12 rd held", {30'b0, rd_req, wr_req}, 32'h2);
    cfg(2'd0, 3'd5, 16'h0000);
    chk("R2 disabled", {30'b0, active[0], enable[0]}, 32'h0);
    auto_rd = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 no further", rd_n - rb, 32'd1);

    // R8 R9: repeat with destination reload, interrupt
    b = wr_n; rb = rd_n;
    prog(2'd1, 32'h0300_0100, 32'h0300_0400, 16'd2, 16'h0393);
    pulse(3'b010);
    wait_idle(200);
    repeat (2) @(negedge clk);
    chk("R9 irq", irq_cnt[1], 32'd1);
    chk("R8 rpt en kept", {30'b0, enable[1], active[1]}, 32'h2);
    chk("R8 wr1", wr_log[(b + 1) % 64], 32'h0300_0402);
    pulse(3'b010);
    wait_idle(200);
    chk("R8 dst reload", wr_log[(b + 2) % 64], 32'h0300_0400);
    chk("R8 src not reloaded", rd_log[(rb + 2) % 64], 32'h0300_0104);
    cfg(2'd1, 3'd5, 16'h0000);

    // R10 R11: audio mode
    prog(2'd0, 32'h0000_5000, 32'h0400_00A0, 16'd7, 16'h02C0);
    b = wr_n; rb = rd_n;
    prog(2'd2, 32'h0200_0000, 32'h0400_00A0, 16'd7, 16'h02C0);
    pulse(3'b100);
    chk("R11 fifo only ch2", {28'b0, active}, 32'h4);
    wait_idle(200);
    chk("R10 count 4", wr_n - b, 32'd4);
    chk("R10 dst fixed", wr_log[(b + 3) % 64], 32'h0400_00A0);
    chk("R10 src step 4", rd_log[(rb + 1) % 64], 32'h0200_0004);
    chk("R10 wide", {31'b0, wide_log[rb % 64]}, 32'h1);
    cfg(2'd0, 3'd5, 16'h0000);

    // R13: start pulse in the completion cycle
    b = wr_n;
    prog(2'd1, 32'h0300_0200, 32'h0300_0300, 16'd1, 16'h0250);
    auto_wr = 1'b0;
    pulse(3'b001);
    while (!wr_req) @(negedge clk);
    man_wr = 1'b1; trig = 3'b001;
    @(negedge clk);
    man_wr = 1'b0; trig = '0;
    chk("R13 still active", {31'b0, active[1]}, 32'h1);
    auto_wr = 1'b1;
    wait_idle(200);
    chk("R13 two blocks", wr_n - b, 32'd2);
    cfg(2'd1, 3'd5, 16'h0000);

    // R7: zero count
    b = wr_n;
    prog(2'd0, 32'h0000_6000, 32'h0200_2000, 16'd0, 16'h020A);
    wait_idle(70000);
    chk("R7 ch0 zero", wr_n - b, 32'h4000);
    b = wr_n;
    prog(2'd3, 32'h0000_7000, 32'h0200_3000, 16'd0, 16'h020A);
    begin
      int c = 0;
      while ((wr_n - b) < 32'h4000 && c < 70000) begin
        @(negedge clk);
        c++;
      end
    end
    chk("R7 ch3 beyond 0x4000", {31'b0, active[3]}, 32'h1);
    cfg(2'd3, 3'd5, 16'h0000);
    wait_idle(50);

    summary();
  end
endmodule